// File: doc/BRIEF.md
# Per-VC Credit Flow Control for a Router Link Transmitter

This block sits on the sending side of a link between two routers. For every virtual channel it holds a count of the buffer slots still free in the downstream router. Each counter starts at the downstream per-VC buffer depth and loses one slot whenever a flit goes out on that VC. The downstream router returns slots one at a time over a credit-return port, and each return adds one slot back. A per-VC `can_send` vector tells the switch allocator which VCs may win the link this cycle. A VC with no free slot downstream cannot win.

The flit port is a valid/ready handshake. The allocator presents `tx_valid` with the chosen `tx_vc`. The flit counts as sent on a rising clock edge where both `tx_valid` and `tx_ready` are high. `tx_valid` may be held or dropped freely while `tx_ready` is low, and no flit is counted in that case. The credit-return port has no ready: every return is taken on the cycle it is presented.

A mode pin selects a simpler on/off scheme in place of counting. In that mode the downstream router reports its total buffer occupancy. The block turns that report into one stop/go signal with hysteresis. The signal stops the link early, leaving enough room to absorb the flits still in flight during the round trip. All VCs then share that single go signal, and the credit counters hold their values.

Top module: `credit_flow_ctrl`

## Requirements
- R1: After reset every VC counter equals BUF_DEPTH, `can_send` is all ones, `credit_err` is 0 and the on/off go state is 1.
- R2: With `onoff_mode`=0, `tx_ready` equals `can_send[tx_vc]`. A flit sent on VC v with no return to v in the same cycle lowers v's count by one.
- R3: With `onoff_mode`=0, `can_send[v]` is 1 exactly when VC v's count is non-zero. A count never exceeds BUF_DEPTH.
- R4: With `onoff_mode`=0, a credit return on VC v whose count is below BUF_DEPTH, with no send on v in that cycle, raises the count by one.
- R5: A send and a credit return on the same VC in the same cycle leave that count unchanged.
- R6: A credit return on a VC already at BUF_DEPTH, with no send on it, leaves the count unchanged and sets `credit_err`. `credit_err` stays set until reset.
- R7: A send on one VC and a return on another VC in the same cycle each update only their own counter.
- R8: The go state drops one cycle after `ds_occ` is at least OFF_LVL = NUM_VC*BUF_DEPTH - RTT_FLITS while go is 1.
- R9: The go state rises one cycle after `ds_occ` is below ON_LVL = OFF_LVL - HYST_GAP while go is 0. Otherwise go holds its value.
- R10: With `onoff_mode`=1, every bit of `can_send` and `tx_ready` equals the go state. Sends and credit returns change no counter and never set `credit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| onoff_mode | input | 1 | 0: per-VC credit counting, 1: on/off stop/go |
| tx_valid | input | 1 | Allocator offers a flit this cycle |
| tx_vc | input | VC_W | VC of the offered flit |
| tx_ready | output | 1 | Flit may be sent; send happens when valid and ready |
| cr_valid | input | 1 | A credit is returned this cycle |
| cr_vc | input | VC_W | VC the returned credit belongs to |
| ds_occ | input | OCC_W | Downstream total buffer occupancy (on/off mode) |
| can_send | output | NUM_VC | Per-VC permission to the switch allocator |
| credit_err | output | 1 | Sticky: a credit return overflowed a counter |

## Verification
The bench uses the defaults: 4 VCs, a depth of 4 slots, a 2-flit round trip and a hysteresis gap of 2, which puts OFF_LVL at 14 and ON_LVL at 12. With a depth this shallow, random traffic drains VCs to zero and refills them to the cap many times. Same-cycle send/return collisions on one VC also occur often. The 0..16 occupancy range crosses both thresholds, so each edge of the hysteresis band is exercised.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_INC  = 2'b01,
    CNT_DEC  = 2'b10,
    CNT_BOTH = 2'b11
  } cnt_op_e;

  function automatic int unsigned occ_width(input int unsigned total);
    return $clog2(total + 1);
  endfunction
endpackage

// File: rtl/vc_credit_counter.sv
module vc_credit_counter #(
  parameter int unsigned BUF_DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] count,
  output logic             nonzero,
  output logic             overflow
);
  import cfc_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_DEPTH);

  cnt_op_e op;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    op       = cnt_op_e'({take & enable, give & enable});
    cnt_d    = cnt_q;
    overflow = 1'b0;
    unique case (op)
      CNT_DEC: cnt_d = cnt_q - 1'b1;
      CNT_INC: begin
        if (cnt_q == FULL) overflow = 1'b1;
        else               cnt_d    = cnt_q + 1'b1;
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/onoff_gate.sv
module onoff_gate #(
  parameter int unsigned OCC_W  = 5,
  parameter int unsigned OFF_LVL = 14,
  parameter int unsigned ON_LVL  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  output logic             go
);
  localparam logic [OCC_W-1:0] OFF_T = OCC_W'(OFF_LVL);
  localparam logic [OCC_W-1:0] ON_T  = OCC_W'(ON_LVL);

  logic go_q, go_d;

  always_comb begin
    go_d = go_q;
    if (go_q && (occ >= OFF_T))     go_d = 1'b0;
    else if (!go_q && (occ < ON_T)) go_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b1;
    else        go_q <= go_d;
  end

  assign go = go_q;
endmodule

// File: rtl/credit_flow_ctrl.sv
module credit_flow_ctrl #(
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned BUF_DEPTH = 4,
  parameter int unsigned RTT_FLITS = 2,
  parameter int unsigned HYST_GAP  = 2,
  localparam int unsigned VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int unsigned LINK_CAP = NUM_VC * BUF_DEPTH,
  localparam int unsigned OCC_W    = cfc_pkg::occ_width(LINK_CAP),
  localparam int unsigned OFF_LVL  = LINK_CAP - RTT_FLITS,
  localparam int unsigned ON_LVL   = OFF_LVL - HYST_GAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              onoff_mode,
  input  logic              tx_valid,
  input  logic [VC_W-1:0]   tx_vc,
  output logic              tx_ready,
  input  logic              cr_valid,
  input  logic [VC_W-1:0]   cr_vc,
  input  logic [OCC_W-1:0]  ds_occ,
  output logic [NUM_VC-1:0] can_send,
  output logic              credit_err
);
  logic [NUM_VC-1:0]       has_credit;
  logic [NUM_VC-1:0]       ovf;
  logic [NUM_VC*CNT_W-1:0] cnt_flat;
  logic                    go_q;
  logic                    fire;
  logic                    err_q;

  assign fire = tx_valid & tx_ready;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CNT_W-1:0] cnt_v;
    vc_credit_counter #(.BUF_DEPTH(BUF_DEPTH)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (!onoff_mode),
      .take     (fire && (tx_vc == VC_W'(v))),
      .give     (cr_valid && (cr_vc == VC_W'(v))),
      .count    (cnt_v),
      .nonzero  (has_credit[v]),
      .overflow (ovf[v])
    );
    assign cnt_flat[v*CNT_W +: CNT_W] = cnt_v;
  end

  onoff_gate #(.OCC_W(OCC_W), .OFF_LVL(OFF_LVL), .ON_LVL(ON_LVL)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .occ   (ds_occ),
    .go    (go_q)
  );

  assign can_send = onoff_mode ? {NUM_VC{go_q}} : has_credit;
  assign tx_ready = can_send[tx_vc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_q <= 1'b0;
    else if (|ovf) err_q <= 1'b1;
  end

  assign credit_err = err_q;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned BUF_DEPTH = 4,
  parameter int unsigned VC_W      = 2,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned OCC_W     = 5,
  parameter int unsigned OFF_LVL   = 14,
  parameter int unsigned ON_LVL    = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    onoff_mode,
  input logic                    tx_valid,
  input logic                    tx_ready,
  input logic [VC_W-1:0]         tx_vc,
  input logic                    cr_valid,
  input logic [VC_W-1:0]         cr_vc,
  input logic [OCC_W-1:0]        ds_occ,
  input logic                    credit_err,
  input logic [NUM_VC*CNT_W-1:0] cnt_flat,
  input logic                    go_q
);
  always @(posedge clk) begin
    if (rst_n) begin
      for (int v = 0; v < NUM_VC; v++) begin
        assert_cap_R3: assert (cnt_flat[v*CNT_W +: CNT_W] <= CNT_W'(BUF_DEPTH))
          else $error("count above depth on VC %0d", v);
      end
    end
  end

  assert_send_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!onoff_mode && tx_valid && tx_ready && !cr_valid) |=> (cnt_flat != $past(cnt_flat)));

  assert_same_vc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!onoff_mode && tx_valid && tx_ready && cr_valid && (tx_vc == cr_vc)) |=> $stable(cnt_flat));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    credit_err |=> credit_err);

  assert_go_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && (ds_occ >= OCC_W'(OFF_LVL))) |=> !go_q);

  assert_go_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_q && (ds_occ < OCC_W'(ON_LVL))) |=> go_q);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    onoff_mode |=> $stable(cnt_flat));
endmodule

bind credit_flow_ctrl cfc_checker #(
  .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH), .VC_W(VC_W), .CNT_W(CNT_W),
  .OCC_W(OCC_W), .OFF_LVL(OFF_LVL), .ON_LVL(ON_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .onoff_mode(onoff_mode), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_vc(tx_vc), .cr_valid(cr_valid), .cr_vc(cr_vc),
  .ds_occ(ds_occ), .credit_err(credit_err), .cnt_flat(cnt_flat), .go_q(go_q)
);

// File: tb/tb_credit_flow_ctrl.sv
module tb_credit_flow_ctrl;
  localparam int NV = 4;
  localparam int D  = 4;
  localparam int OFF_LVL = NV*D - 2;
  localparam int ON_LVL  = OFF_LVL - 2;

  logic clk = 0;
  logic rst_n = 0;
  logic onoff_mode = 0;
  logic tx_valid = 0;
  logic [1:0] tx_vc = 0;
  logic tx_ready;
  logic cr_valid = 0;
  logic [1:0] cr_vc = 0;
  logic [4:0] ds_occ = 0;
  logic [NV-1:0] can_send;
  logic credit_err;

  always #2.5 clk = ~clk;

  credit_flow_ctrl dut (.*);

  int m_cnt [NV];
  bit m_err, m_go;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [NV-1:0] exp_can(bit mode);
    logic [NV-1:0] r;
    for (int v = 0; v < NV; v++) r[v] = mode ? m_go : (m_cnt[v] != 0);
    return r;
  endfunction

  function automatic bit exp_go_next(bit go, int occ);
    if (go && occ >= OFF_LVL) return 0;
    if (!go && occ < ON_LVL) return 1;
    return go;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < NV; v++) m_cnt[v] = D;
    m_err = 0;
    m_go = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tx_valid = 0; cr_valid = 0; onoff_mode = 0; ds_occ = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // One cycle: drive at negedge, compare outputs, then advance model over the edge
  task automatic step(bit md, bit tv, int tvc, bit cv, int cvc, int occ, string tag);
    logic [NV-1:0] ec;
    bit er, fire, take, give;
    @(negedge clk);
    onoff_mode = md; tx_valid = tv; tx_vc = 2'(tvc);
    cr_valid = cv; cr_vc = 2'(cvc); ds_occ = 5'(occ);
    #1;
    ec = exp_can(md);
    er = ec[tvc];
    chk(can_send === ec, tag, int'(can_send), int'(ec));
    chk(tx_ready === er, tag, int'(tx_ready), int'(er));
    chk(credit_err === m_err, tag, int'(credit_err), int'(m_err));
    fire = tv && er;
    if (!md) begin
      take = fire;
      give = cv;
      if (take && give && tvc == cvc) begin
      end else begin
        if (take) m_cnt[tvc]--;
        if (give) begin
          if (m_cnt[cvc] == D) m_err = 1;
          else m_cnt[cvc]++;
        end
      end
    end
    m_go = exp_go_next(m_go, occ);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    do_reset();
    // R1: reset state
    #1;
    chk(can_send === 4'hF, "R1", int'(can_send), 15);
    chk(credit_err === 0, "R1", int'(credit_err), 0);
    chk(tx_ready === 1, "R1", int'(tx_ready), 1);
    step(1, 0, 0, 0, 0, 0, "R1");            // go=1 after reset
    // R2/R3: drain VC0, the extra offers must be refused
    for (int i = 0; i < D + 2; i++) step(0, 1, 0, 0, 0, 0, "R2_R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    // R4: refill one slot
    step(0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    // R5: same VC send+return on VC1
    step(0, 1, 1, 1, 1, 0, "R5");
    step(0, 1, 1, 1, 1, 0, "R5");
    // R7: send VC2, return VC0
    step(0, 1, 2, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    // R6: overflow on full VC3
    step(0, 0, 0, 1, 3, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    do_reset();
    // R8/R9: hysteresis thresholds
    step(1, 1, 0, 0, 0, OFF_LVL - 1, "R8");
    step(1, 1, 0, 0, 0, OFF_LVL, "R8");
    step(1, 1, 0, 0, 0, ON_LVL, "R9");
    step(1, 1, 0, 0, 0, ON_LVL - 1, "R9");
    step(1, 1, 0, 0, 0, 0, "R9");
    // R10: on/off mode freezes counters and ignores overflow
    for (int i = 0; i < 6; i++) step(1, 1, 2, 1, 3, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < D + 1; i++) step(0, 1, 2, 0, 0, 0, "R10");
    do_reset();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit md, tv, cv;
      int tvc, cvc, occ;
      md  = ($urandom % 8) == 0;
      tv  = $urandom % 2;
      tvc = $urandom % NV;
      cv  = ($urandom % 3) != 0;
      cvc = $urandom % NV;
      occ = $urandom % (NV*D + 1);
      if (!md && cv && m_cnt[cvc] == D && !(tv && tvc == cvc)) cv = 0;
      step(md, tv, tvc, cv, cvc, occ, md ? "R10_R8_R9" : "R2_R3_R4_R5_R7");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule